// File: doc/BRIEF.md
# Host Byte Window into Controller Memory

This block places eight byte-wide registers on a host I/O port and uses them to reach a 32-bit local memory inside an embedded controller, one host byte at a time. The host loads a word address and an access mode into two address bytes. It then moves data through four data bytes. A 32-bit staging register gathers or spreads whole words or halfwords, so the memory sees one full-width access where the mode allows it.

Two one-byte mailboxes share the window, one in each direction. Each has a full flag that the writer sets and the reader clears. The memory port is combinational. A host read strobe yields its byte on the host data output one cycle later.

Top module: `host_mem_window`

## Requirements
- R1: A host write to offset 2 or 3 stores the low or high address byte, and a host read returns it; bit 7 of the high byte is ignored and reads 0. The word address is {high[6:0], low[7:2]} and the mode is low[1:0]: 0 byte, 1 halfword, 2 word, 3 word with auto-increment.
- R2: A host read strobe on any offset puts the selected byte on host_rdata at the first rising edge after the strobe.
- R3: In modes 2 and 3, a host read of offset 4 reads the addressed word (mem_re, mem_be=1111) into staging and returns byte lane 0. Reads of offsets 5 to 7 return staged lanes 1 to 3 and raise no mem_re.
- R4: In modes 2 and 3, host writes to offsets 4 to 6 only fill staging lanes 0 to 2 and raise no mem_we. A write to offset 7 writes all four staged lanes, with the new lane 3, to memory with mem_be=1111.
- R5: In mode 3, a host read or write of offset 7 adds one to the word address after the access, and the address wraps from 0x1FFF to 0.
- R6: In mode 0, offset 4+n reads or writes only byte lane n of the addressed word (mem_be has bit n alone set), and the address does not change.
- R7: In mode 1, a read of offset 4 or 6 fetches lanes 0-1 or 2-3 into staging, and a read of 5 or 7 returns staging alone. Writes of 4 or 6 only stage. A write of 5 or 7 commits lanes 0-1 or 2-3 with two byte enables.
- R8: A host write of either address byte discards staged data: staging becomes zero, and a later commit writes zero in the lanes that were not restaged.
- R9: A host write to offset 0 stores the byte for the local side and sets ec_h2e_full, and ec_h2e_rd clears it. When both happen in one cycle, the flag stays set and the new byte is held.
- R10: ec_e2h_wr stores a byte and sets host_e2h_full, and a host read of offset 1 returns the byte and clears the flag. When both happen in one cycle, the host receives the previous byte and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_off | input | 3 | Host register offset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid one cycle after the strobe |
| host_e2h_full | output | 1 | Controller-to-host mailbox holds unread data |
| mem_addr | output | 13 | Word address to local memory |
| mem_re | output | 1 | Memory read, data taken the same cycle |
| mem_we | output | 1 | Memory write |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, combinational |
| ec_h2e_rd | input | 1 | Local side consumes the host-to-controller byte |
| ec_h2e_data | output | 8 | Host-to-controller mailbox byte |
| ec_h2e_full | output | 1 | Host-to-controller mailbox holds unread data |
| ec_e2h_wr | input | 1 | Local side writes the controller-to-host byte |
| ec_e2h_wdata | input | 8 | Controller-to-host byte |

## Verification
Each mailbox flag has two owners: the host sets it and the local side clears it, or the reverse. The two can act in the same cycle. The bench provokes this by raising the host strobe and the local strobe on the same clock while the flag is already set. It then judges that the flag stays set, that the new byte is held, and that a same-cycle host read returns the older byte. The bench also drives an auto-increment access on data byte 3 and checks the read data and the address advance that come out of that one strobe.

// File: rtl/host_mem_window.sv
module host_mem_window (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  host_off,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        host_e2h_full,
  output logic [12:0] mem_addr,
  output logic        mem_re,
  output logic        mem_we,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        ec_h2e_rd,
  output logic [7:0]  ec_h2e_data,
  output logic        ec_h2e_full,
  input  logic        ec_e2h_wr,
  input  logic [7:0]  ec_e2h_wdata
);

  localparam logic [1:0] M_BYTE = 2'd0;
  localparam logic [1:0] M_HALF = 2'd1;
  localparam logic [1:0] M_AUTO = 2'd3;

  logic [7:0]  addr_lo;
  logic [6:0]  addr_hi;
  logic [31:0] stg;
  logic [7:0]  e2h_q;
  logic [12:0] waddr;
  logic [1:0]  mode;
  logic [1:0]  lane;
  logic        is_data, rd_acc, wr_acc, bump, addr_wr;
  logic [3:0]  acc_be;
  logic [7:0]  rd_lane, stg_lane;

  assign mode    = addr_lo[1:0];
  assign waddr   = {addr_hi, addr_lo[7:2]};
  assign lane    = host_off[1:0];
  assign is_data = host_off[2];
  assign addr_wr = host_wr && (host_off == 3'd2 || host_off == 3'd3);
  assign bump    = (host_rd || host_wr) && is_data && lane == 2'd3 && mode == M_AUTO;

  always_comb begin
    case (mode)
      M_BYTE: begin
        acc_be = 4'b0001 << lane;
        rd_acc = 1'b1;
        wr_acc = 1'b1;
      end
      M_HALF: begin
        acc_be = lane[1] ? 4'b1100 : 4'b0011;
        rd_acc = !lane[0];
        wr_acc = lane[0];
      end
      default: begin
        acc_be = 4'b1111;
        rd_acc = (lane == 2'd0);
        wr_acc = (lane == 2'd3);
      end
    endcase
  end

  assign mem_addr = waddr;
  assign mem_re   = host_rd && is_data && rd_acc;
  assign mem_we   = host_wr && is_data && wr_acc;
  assign mem_be   = (mem_re || mem_we) ? acc_be : 4'b0000;

  always_comb begin
    mem_wdata = stg;
    mem_wdata[{lane, 3'b000} +: 8] = host_wdata;
  end

  assign rd_lane  = mem_rdata[{lane, 3'b000} +: 8];
  assign stg_lane = stg[{lane, 3'b000} +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo <= 8'h00;
      addr_hi <= 7'h00;
    end else if (host_wr && host_off == 3'd2) begin
      addr_lo <= host_wdata;
    end else if (host_wr && host_off == 3'd3) begin
      addr_hi <= host_wdata[6:0];
    end else if (bump) begin
      {addr_hi, addr_lo[7:2]} <= waddr + 13'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= 32'h0;
    end else if (addr_wr) begin
      stg <= 32'h0;
    end else if (host_wr && is_data && mode != M_BYTE) begin
      stg[{lane, 3'b000} +: 8] <= host_wdata;
    end else if (mem_re && mode != M_BYTE) begin
      for (int i = 0; i < 4; i++)
        if (acc_be[i]) stg[i*8 +: 8] <= mem_rdata[i*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= 8'h00;
    end else if (host_rd) begin
      case (host_off)
        3'd0:    host_rdata <= ec_h2e_data;
        3'd1:    host_rdata <= e2h_q;
        3'd2:    host_rdata <= addr_lo;
        3'd3:    host_rdata <= {1'b0, addr_hi};
        default: host_rdata <= mem_re ? rd_lane : stg_lane;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ec_h2e_data <= 8'h00;
      ec_h2e_full <= 1'b0;
    end else if (host_wr && host_off == 3'd0) begin
      ec_h2e_data <= host_wdata;
      ec_h2e_full <= 1'b1;
    end else if (ec_h2e_rd) begin
      ec_h2e_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e2h_q         <= 8'h00;
      host_e2h_full <= 1'b0;
    end else if (ec_e2h_wr) begin
      e2h_q         <= ec_e2h_wdata;
      host_e2h_full <= 1'b1;
    end else if (host_rd && host_off == 3'd1) begin
      host_e2h_full <= 1'b0;
    end
  end

  p_no_rw_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  p_word_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_off == 3'd7 && mode[1]) |-> (mem_we && mem_be == 4'hF));

  p_byte_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_we || mem_re) && mode == M_BYTE) |-> ($countones(mem_be) == 1));

  p_autoinc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bump |=> (waddr == $past(waddr) + 13'd1));

  p_addr_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (stg == 32'h0));

  p_h2e_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_off == 3'd0) |=> ec_h2e_full);

  p_e2h_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ec_e2h_wr |=> host_e2h_full);

endmodule

// File: tb/host_mem_window_tb.sv
module host_mem_window_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_off = 3'd0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        host_e2h_full;
  logic [12:0] mem_addr;
  logic        mem_re, mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic        ec_h2e_rd = 1'b0;
  logic [7:0]  ec_h2e_data;
  logic        ec_h2e_full;
  logic        ec_e2h_wr = 1'b0;
  logic [7:0]  ec_e2h_wdata = 8'h00;

  int checks = 0, errors = 0;
  int re_cnt = 0, we_cnt = 0;
  logic [3:0]  last_be = 4'h0;
  logic [31:0] mem [0:63];

  always #10 clk = ~clk;

  host_mem_window u_dut (
    .clk(clk), .rst_n(rst_n), .host_off(host_off), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_e2h_full(host_e2h_full), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ec_h2e_rd(ec_h2e_rd), .ec_h2e_data(ec_h2e_data),
    .ec_h2e_full(ec_h2e_full), .ec_e2h_wr(ec_e2h_wr),
    .ec_e2h_wdata(ec_e2h_wdata)
  );

  assign mem_rdata = mem[mem_addr[5:0]];

  always @(posedge clk) begin
    if (mem_re) re_cnt <= re_cnt + 1;
    if (mem_we) begin
      we_cnt  <= we_cnt + 1;
      last_be <= mem_be;
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) mem[mem_addr[5:0]][i*8 +: 8] <= mem_wdata[i*8 +: 8];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(logic [2:0] off, logic [7:0] d);
    @(negedge clk);
    host_off = off; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hrd(logic [2:0] off, output logic [7:0] d);
    @(negedge clk);
    host_off = off; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic t_reset();
    chk("R2 reset rdata", host_rdata, 0);
    chk("R9 reset h2e flag", ec_h2e_full, 0);
    chk("R10 reset e2h flag", host_e2h_full, 0);
    chk("R1 reset addr", mem_addr, 0);
  endtask

  task automatic t_addr();
    logic [7:0] d;
    hwr(3'd2, 8'h5E);
    hwr(3'd3, 8'hFF);
    hrd(3'd2, d); chk("R1 low readback", d, 8'h5E);
    hrd(3'd3, d); chk("R1 high bit7 ignored", d, 8'h7F);
    chk("R1 word address", mem_addr, 13'h1FD7);
  endtask

  task automatic t_word();
    logic [7:0] d;
    int re0, we0;
    hwr(3'd3, 8'h00); hwr(3'd2, 8'h16);
    mem[5] = 32'h11223344;
    re0 = re_cnt;
    hrd(3'd4, d); chk("R3 byte0 fetch", d, 8'h44);
    chk("R3 one fetch", re_cnt - re0, 1);
    hrd(3'd5, d); chk("R3 byte1 staged", d, 8'h33);
    hrd(3'd6, d); chk("R2 R3 byte2 staged", d, 8'h22);
    hrd(3'd7, d); chk("R3 byte3 staged", d, 8'h11);
    chk("R3 no extra fetch", re_cnt - re0, 1);
    we0 = we_cnt;
    hwr(3'd4, 8'hA1); hwr(3'd5, 8'hA2); hwr(3'd6, 8'hA3);
    chk("R4 no write before byte3", we_cnt - we0, 0);
    chk("R4 memory untouched", mem[5], 32'h11223344);
    hwr(3'd7, 8'hA4);
    chk("R4 flush word", mem[5], 32'hA4A3A2A1);
    chk("R4 flush enables", last_be, 4'hF);
    hrd(3'd2, d); chk("R4 no advance in mode 2", d, 8'h16);
  endtask

  task automatic t_auto();
    logic [7:0] d;
    hwr(3'd3, 8'h00); hwr(3'd2, 8'h1F);
    hwr(3'd4, 8'h01); hwr(3'd5, 8'h02); hwr(3'd6, 8'h03); hwr(3'd7, 8'h04);
    chk("R5 write word7", mem[7], 32'h04030201);
    hrd(3'd2, d); chk("R5 advance after write", d, 8'h23);
    mem[8] = 32'hCAFEF00D;
    hrd(3'd4, d); chk("R5 read byte0", d, 8'h0D);
    hrd(3'd5, d); hrd(3'd6, d);
    hrd(3'd2, d); chk("R5 no advance before byte3", d, 8'h23);
    hrd(3'd7, d); chk("R5 read byte3", d, 8'hCA);
    hrd(3'd2, d); chk("R5 advance after read", d, 8'h27);
    hwr(3'd2, 8'hFF); hwr(3'd3, 8'h7F);
    mem[63] = 32'h0BADBEEF;
    hrd(3'd4, d); hrd(3'd7, d); chk("R5 read at max", d, 8'h0B);
    hrd(3'd2, d); chk("R5 wrap low", d, 8'h03);
    hrd(3'd3, d); chk("R5 wrap high", d, 8'h00);
  endtask

  task automatic t_byte();
    logic [7:0] d;
    hwr(3'd3, 8'h00); hwr(3'd2, 8'h24);
    mem[9] = 32'h0;
    hwr(3'd6, 8'h5A);
    chk("R6 lane2 write", mem[9], 32'h005A0000);
    chk("R6 lane2 enable", last_be, 4'b0100);
    mem[9] = 32'h44332211;
    hrd(3'd5, d); chk("R6 lane1 read", d, 8'h22);
    hrd(3'd7, d); chk("R6 lane3 read", d, 8'h44);
    hrd(3'd2, d); chk("R6 no advance", d, 8'h24);
  endtask

  task automatic t_half();
    logic [7:0] d;
    int re0, we0;
    hwr(3'd3, 8'h00); hwr(3'd2, 8'h29);
    mem[10] = 32'h89ABCDEF;
    re0 = re_cnt;
    hrd(3'd6, d); chk("R7 upper fetch", d, 8'hAB);
    hrd(3'd7, d); chk("R7 upper staged", d, 8'h89);
    chk("R7 single fetch", re_cnt - re0, 1);
    we0 = we_cnt;
    hwr(3'd4, 8'h01);
    chk("R7 stage only", we_cnt - we0, 0);
    hwr(3'd5, 8'h02);
    chk("R7 lower commit", mem[10], 32'h89AB0201);
    chk("R7 two enables", last_be, 4'b0011);
  endtask

  task automatic t_clear();
    hwr(3'd3, 8'h00); hwr(3'd2, 8'h2E);
    mem[11] = 32'hFFFFFFFF;
    hwr(3'd4, 8'hAA); hwr(3'd5, 8'hBB);
    hwr(3'd2, 8'h2E);
    hwr(3'd7, 8'h55);
    chk("R8 staged bytes dropped", mem[11], 32'h55000000);
  endtask

  task automatic t_mbox();
    logic [7:0] d;
    hwr(3'd0, 8'h3C);
    chk("R9 h2e flag set", ec_h2e_full, 1);
    chk("R9 h2e data", ec_h2e_data, 8'h3C);
    @(negedge clk); ec_h2e_rd = 1'b1;
    @(negedge clk); ec_h2e_rd = 1'b0;
    chk("R9 h2e flag cleared", ec_h2e_full, 0);
    hwr(3'd0, 8'h11);
    @(negedge clk);
    host_off = 3'd0; host_wdata = 8'h22; host_wr = 1'b1; ec_h2e_rd = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; ec_h2e_rd = 1'b0;
    chk("R9 same cycle set wins", ec_h2e_full, 1);
    chk("R9 same cycle new byte", ec_h2e_data, 8'h22);
    @(negedge clk); ec_e2h_wdata = 8'h77; ec_e2h_wr = 1'b1;
    @(negedge clk); ec_e2h_wr = 1'b0;
    chk("R10 e2h flag set", host_e2h_full, 1);
    hrd(3'd1, d); chk("R10 e2h read", d, 8'h77);
    chk("R10 e2h flag cleared", host_e2h_full, 0);
    @(negedge clk);
    ec_e2h_wdata = 8'h88; ec_e2h_wr = 1'b1; host_off = 3'd1; host_rd = 1'b1;
    @(negedge clk);
    ec_e2h_wr = 1'b0; host_rd = 1'b0;
    chk("R10 same cycle old byte", host_rdata, 8'h77);
    chk("R10 same cycle set wins", host_e2h_full, 1);
    hrd(3'd1, d); chk("R10 newer byte", d, 8'h88);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_addr();
    t_word();
    t_auto();
    t_byte();
    t_half();
    t_clear();
    t_mbox();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule